// File: doc/BRIEF.md
# Event-Timed SPI Start Trigger

This block launches a pending SPI transfer at a precise moment set by external timing hardware. It watches a bank of up to 32 event lines (a frame sync, a line-count event, a PWM frame pulse and others). A 5-bit select picks one line. When the chosen line shows an edge of the enabled polarity, the block waits a programmable number of clock cycles and then sends a single-cycle start pulse to one of four downstream transfer engines.

All settings come from one 32-bit configuration word, written in a single cycle. Bit 31 of the word is a master enable that gates the whole path. Each event line is synchronised through two flops before its edges are detected, so the lines may be asynchronous to the block clock. Two static inputs choose which edge counts: rising, falling, either, or none.

Top module: `spi_trig_mux`

## Requirements
- R1: While rst_ni is low and after reset is released, start_o is all zero, and the configuration word is cleared, which leaves the enable off.
- R2: Only the event line whose index equals configuration bits [4:0] can trigger. Codes 10, 13 and 16 are typical sources. Edges on every other line have no effect on start_o.
- R3: With the sampling edge of an event change counted as cycle 1, the start pulse is high exactly in the cycle after rising edge D+3. D is the delay in configuration bits [30:7]. The pulse lasts one cycle.
- R4: A programmed delay of 0 or 1 behaves exactly as a delay of 2.
- R5: While configuration bit 31 is 0, no start pulse is emitted, whatever the events do.
- R6: Writing a word with bit 31 cleared while a delay count is running cancels that count, and no start pulse follows it.
- R7: rise_en_i makes 0-to-1 transitions of the selected line trigger. fall_en_i makes 1-to-0 transitions trigger. With both set either transition triggers, and with neither set nothing triggers.
- R8: A qualifying edge that arrives while a delay count is running is ignored. It neither restarts the count nor produces a second pulse.
- R9: Configuration bits [6:5] choose which bit of start_o carries the pulse. At most one bit of start_o is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Loads cfg_wdata_i into the configuration word |
| cfg_wdata_i | input | 32 | Configuration word: source [4:0], output select [6:5], delay [30:7], enable [31] |
| rise_en_i | input | 1 | Rising edges of the selected event trigger |
| fall_en_i | input | 1 | Falling edges of the selected event trigger |
| evt_i | input | 32 | Asynchronous timing event lines |
| start_o | output | 4 | One-cycle start pulse, routed by output select |

## Verification
A wrong count or a wrong load value changes where the pulse lands. The sweep checks the exact cycle, so an off-by-one appears at the first triggered transfer. A stuck busy state makes later triggers go missing, which shows up within one delay window. A bad abort or a bad enable gate shows up as a stray pulse in a window where the bench expects none. A routing fault lands the pulse on the wrong start_o bit, and the sweep catches this on the first run with that output select.

// File: rtl/spi_trig_pkg.sv
package spi_trig_pkg;
  localparam int unsigned SRC_W   = 5;
  localparam int unsigned OSEL_W  = 2;
  localparam int unsigned DLY_W   = 24;
  localparam int unsigned NUM_SRC = 1 << SRC_W;
  localparam int unsigned NUM_OUT = 1 << OSEL_W;
  localparam int unsigned MIN_DLY = 2;

  // field order fixed by the programming word layout
  typedef struct packed {
    logic              en;
    logic [DLY_W-1:0]  dly;
    logic [OSEL_W-1:0] osel;
    logic [SRC_W-1:0]  src;
  } trig_cfg_t;
endpackage

// File: rtl/spi_trig_sync.sv
module spi_trig_sync #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= evt_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/spi_trig_delay.sv
module spi_trig_delay #(
  parameter int unsigned DLY_W   = 24,
  parameter int unsigned MIN_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             edge_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o,
  output logic             busy_o,
  output logic [DLY_W-1:0] cnt_o
);
  localparam logic [DLY_W-1:0] MIN_V = DLY_W'(MIN_DLY);

  logic             busy_q, fire_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] eff_dly;

  assign eff_dly = (dly_i < MIN_V) ? MIN_V : dly_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fire_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      fire_q <= 1'b0;
      if (!en_i) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (edge_i) begin
        busy_q <= 1'b1;
        cnt_q  <= eff_dly - 1'b1;
      end
    end
  end

  assign fire_o = fire_q;
  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/spi_trig_mux.sv
module spi_trig_mux
  import spi_trig_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [31:0]        cfg_wdata_i,
  input  logic               rise_en_i,
  input  logic               fall_en_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [NUM_OUT-1:0] start_o
);
  trig_cfg_t          cfg_q, cfg_d;
  logic [NUM_SRC-1:0] rise, fall;
  logic               sel_edge;
  logic               fire;
  logic               busy;
  logic [DLY_W-1:0]   cnt;

  assign cfg_d = cfg_we_i ? trig_cfg_t'(cfg_wdata_i) : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  spi_trig_sync #(.N(NUM_SRC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sel_edge = (rise_en_i & rise[cfg_q.src]) | (fall_en_i & fall[cfg_q.src]);

  // next-state enable so a disabling write cancels a pulse due on the same edge
  spi_trig_delay #(.DLY_W(DLY_W), .MIN_DLY(MIN_DLY)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_d.en),
    .edge_i (sel_edge),
    .dly_i  (cfg_q.dly),
    .fire_o (fire),
    .busy_o (busy),
    .cnt_o  (cnt)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_route
    assign start_o[g] = fire & (cfg_q.osel == OSEL_W'(g));
  end
endmodule

// File: rtl/spi_trig_mux_chk.sv
module spi_trig_mux_chk
  import spi_trig_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_OUT-1:0] start_o,
  input logic               en_q,
  input logic               busy,
  input logic [DLY_W-1:0]   cnt
);
  AST_OUT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o)); // R9
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |=> !(|start_o)); // R3
  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (start_o == '0)); // R5
  AST_PULSE_ENDS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> (!busy && $past(busy))); // R8
  AST_MIN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (cnt >= DLY_W'(MIN_DLY - 1))); // R4
endmodule

bind spi_trig_mux spi_trig_mux_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_o (start_o),
  .en_q    (cfg_q.en),
  .busy    (busy),
  .cnt     (cnt)
);

// File: tb/spi_trig_mux_test.sv
`timescale 1ns/1ps
module spi_trig_mux_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        rise_en_i = 1'b1;
  logic        fall_en_i = 1'b0;
  logic [31:0] evt_i = '0;
  logic [3:0]  start_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  spi_trig_mux uut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i,
    .rise_en_i, .fall_en_i, .evt_i, .start_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // word: src [4:0], osel [6:5], delay [30:7], enable [31]
  task automatic wr_cfg(input int src, input int osel, input int dly, input bit en);
    @(negedge clk_i);
    cfg_we_i    = 1'b1;
    cfg_wdata_i = {en, 24'(dly), 2'(osel), 5'(src)};
    @(negedge clk_i);
    cfg_we_i    = 1'b0;
  endtask

  // cycle 1 is the first rising edge after the call
  task automatic watch(input int n, output int first, output int cnt, output int idx);
    first = 0; cnt = 0; idx = -1;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (|start_o) begin
        cnt++;
        if (first == 0) first = i;
        for (int b = 0; b < 4; b++) if (start_o[b]) idx = b;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    int first, cnt, idx, expd;
    int srcs [5] = '{0, 10, 13, 16, 31};
    int dlys [5] = '{0, 1, 2, 3, 6};
    // R1
    idle(3);
    chk(start_o == 4'b0, "R1 reset", int'(start_o), 0);
    rst_ni = 1'b1;
    evt_i = '1;
    watch(10, first, cnt, idx);
    chk(cnt == 0, "R1 enable off after reset", cnt, 0);
    evt_i = '0;
    idle(4);

    // R3 R4 R9 R2 sweep, rising only
    foreach (srcs[s]) for (int o = 0; o < 4; o++) foreach (dlys[d]) begin
      wr_cfg(srcs[s], o, dlys[d], 1'b1);
      expd = ((dlys[d] < 2) ? 2 : dlys[d]) + 3;
      evt_i[srcs[s]] = 1'b1;
      watch(expd + 6, first, cnt, idx);
      chk(first == expd, "R3 R4 latency", first, expd);
      chk(cnt == 1, "R3 single pulse", cnt, 1);
      chk(idx == o, "R9 routing", idx, o);
      evt_i[srcs[s]] = 1'b0;
      watch(12, first, cnt, idx);
      chk(cnt == 0, "R7 falling ignored with rise only", cnt, 0);
    end

    // R3 longer delay
    wr_cfg(13, 2, 300, 1'b1);
    evt_i[13] = 1'b1;
    watch(310, first, cnt, idx);
    chk(first == 303, "R3 long delay", first, 303);
    evt_i[13] = 1'b0;
    idle(6);

    // R2 other lines ignored
    wr_cfg(13, 0, 2, 1'b1);
    evt_i = 32'hFFFF_DFFF;
    watch(15, first, cnt, idx);
    chk(cnt == 0, "R2 unselected lines", cnt, 0);
    evt_i = '0;
    idle(6);

    // R5 disabled
    wr_cfg(16, 1, 2, 1'b0);
    evt_i[16] = 1'b1;
    watch(15, first, cnt, idx);
    chk(cnt == 0, "R5 disabled", cnt, 0);
    evt_i[16] = 1'b0;
    idle(6);

    // R6 abort
    wr_cfg(10, 3, 20, 1'b1);
    evt_i[10] = 1'b1;
    idle(8);
    wr_cfg(10, 3, 20, 1'b0);
    watch(40, first, cnt, idx);
    chk(cnt == 0, "R6 abort", cnt, 0);
    evt_i[10] = 1'b0;
    idle(6);
    wr_cfg(10, 3, 4, 1'b1);
    evt_i[10] = 1'b1;
    watch(12, first, cnt, idx);
    chk(first == 7, "R6 usable after abort", first, 7);
    evt_i[10] = 1'b0;
    idle(6);

    // R8 retrigger ignored
    wr_cfg(10, 1, 10, 1'b1);
    evt_i[10] = 1'b1;
    idle(3);
    evt_i[10] = 1'b0;
    idle(3);
    evt_i[10] = 1'b1;
    watch(40, first, cnt, idx);
    chk(first == 7, "R8 first pulse timing", first, 7);
    chk(cnt == 1, "R8 no second pulse", cnt, 1);
    evt_i[10] = 1'b0;
    idle(6);

    // R7 polarity options
    wr_cfg(16, 0, 5, 1'b1);
    rise_en_i = 1'b0; fall_en_i = 1'b1;
    evt_i[16] = 1'b1;
    watch(15, first, cnt, idx);
    chk(cnt == 0, "R7 rising ignored with fall only", cnt, 0);
    evt_i[16] = 1'b0;
    watch(15, first, cnt, idx);
    chk(first == 8, "R7 falling triggers", first, 8);
    rise_en_i = 1'b1;
    evt_i[16] = 1'b1;
    watch(15, first, cnt, idx);
    chk(first == 8, "R7 both: rising", first, 8);
    evt_i[16] = 1'b0;
    watch(15, first, cnt, idx);
    chk(first == 8, "R7 both: falling", first, 8);
    rise_en_i = 1'b0; fall_en_i = 1'b0;
    evt_i[16] = 1'b1;
    idle(4);
    evt_i[16] = 1'b0;
    watch(20, first, cnt, idx);
    chk(cnt == 0, "R7 none", cnt, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule